// File: doc/BRIEF.md
# Debug Break Injection Sequencer

This block sits beside the instruction decode of a small 8-bit core and turns a hardware breakpoint hit into a software-interrupt entry. An address comparator outside the block raises a match strobe. The core flags the final cycle of every instruction. The sequencer never cuts an instruction short. A match seen mid-instruction is held until the next final-cycle flag. A match that arrives on the final cycle itself is taken at that same boundary, so no further instruction runs.

At the boundary the block overrides the fetched opcode with the software-interrupt opcode for one cycle. It then presents the two vector fetch addresses, high byte first and low byte second. It takes them from the top of memory in normal operation, or from one page lower when the monitor flag is set. The break then stays in service. It ends only when the core reports a return-from-interrupt while the external break request is low. Further matches during service are dropped.

All pins are plain control and status levels or strobes. The core consumes the override and the vector addresses in the cycle they appear, so there is no handshake and no back-pressure.

Top module: `dbg_brk_inject`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, op_force_o and vec_valid_o are 0, op_code_o and vec_addr_o are 0, in_service_o is 0, and no match is pending.
- R2: A match with instr_last_i low is remembered. op_force_o rises in the cycle after the next cycle that has instr_last_i high, and never earlier.
- R3: A match in a cycle with instr_last_i high, while idle, makes op_force_o high in the very next cycle.
- R4: op_force_o is high for exactly one cycle per break, with op_code_o = 8'h83. Otherwise op_code_o is 8'h00.
- R5: In normal mode, vec_valid_o is high for the two cycles after the override cycle. vec_addr_o is 16'hFFFC in the first of them (high byte) and 16'hFFFD in the second (low byte).
- R6: If monitor_i is high in the boundary cycle that starts the break, the two vector addresses are 16'hFEFC then 16'hFEFD.
- R7: in_service_o is high from the override cycle on. It goes low in the cycle after a cycle in the service phase that has rti_done_i high and brk_req_i low.
- R8: rti_done_i while brk_req_i is high leaves the break in service.
- R9: An addr_match_i pulse while in_service_o is high is ignored. After service ends, boundaries without a new match start no break.
- R10: Without a match, no boundary produces an override or a vector fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_match_i | input | 1 | Breakpoint address match strobe |
| instr_last_i | input | 1 | Current cycle is the last of an instruction |
| monitor_i | input | 1 | Monitor mode level, selects the lower vector page |
| rti_done_i | input | 1 | Return-from-interrupt executed strobe |
| brk_req_i | input | 1 | Break request still asserted level |
| op_force_o | output | 1 | One-cycle opcode override strobe |
| op_code_o | output | 8 | Opcode to load into the instruction register |
| vec_valid_o | output | 1 | Vector fetch address is valid |
| vec_addr_o | output | 16 | Vector fetch address |
| in_service_o | output | 1 | A break is being serviced |

## Verification
The bench targets the match that coincides with the final cycle. A design that waits for the following boundary there would run one extra instruction and show the override a whole instruction late. It drives mid-instruction matches followed by long instructions, which catches a design that injects before the boundary or forgets the match. It ends service with the request still high, where a careless exit would drop service early. It also pulses matches during service, and a design that latches them would fire a second break at the next boundary. Monitor mode is toggled right at the boundary, so a wrong vector page or a swapped byte order shows up in the fetch addresses.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  // Sequencer phases: idle, opcode override, vector high, vector low, service
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FORCE = 3'd1,
    ST_VHI   = 3'd2,
    ST_VLO   = 3'd3,
    ST_SVC   = 3'd4
  } brk_st_e;
endpackage

// File: rtl/brk_pend_latch.sv
module brk_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic idle_i,
  input  logic take_i,
  output logic hit_o
);
  logic pend_q;

  // A match counts only while idle; a match during service is dropped
  assign hit_o = idle_i && (pend_q || match_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (take_i) pend_q <= 1'b0;
    else if (hit_o)  pend_q <= 1'b1;
  end
endmodule

// File: rtl/brk_seq_fsm.sv
module brk_seq_fsm
  import dbg_brk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hit_i,
  input  logic    last_i,
  input  logic    rti_i,
  input  logic    req_i,
  output logic    take_o,
  output brk_st_e st_o
);
  brk_st_e st_q, st_d;

  assign take_o = (st_q == ST_IDLE) && hit_i && last_i;
  assign st_o   = st_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (take_o) st_d = ST_FORCE;
      ST_FORCE: st_d = ST_VHI;
      ST_VHI:   st_d = ST_VLO;
      ST_VLO:   st_d = ST_SVC;
      ST_SVC:   if (rti_i && !req_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/brk_vec_gen.sv
module brk_vec_gen
  import dbg_brk_pkg::*;
#(
  parameter int          OP_W     = 8,
  parameter int          ADDR_W   = 16,
  parameter logic [OP_W-1:0]   SWI_OP   = 8'h83,
  parameter logic [ADDR_W-1:0] VEC_NORM = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_MON  = 16'hFEFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              mon_i,
  input  brk_st_e           st_i,
  output logic              force_o,
  output logic [OP_W-1:0]   code_o,
  output logic              vvalid_o,
  output logic [ADDR_W-1:0] vaddr_o
);
  localparam logic [ADDR_W-1:0] LO_OFS = ADDR_W'(1);

  logic              mon_q;
  logic [ADDR_W-1:0] base;

  // Vector page is fixed at the boundary that starts the break
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mon_q <= 1'b0;
    else if (take_i) mon_q <= mon_i;
  end

  assign base     = mon_q ? VEC_MON : VEC_NORM;
  assign force_o  = (st_i == ST_FORCE);
  assign code_o   = force_o ? SWI_OP : '0;
  assign vvalid_o = (st_i == ST_VHI) || (st_i == ST_VLO);

  always_comb begin
    case (st_i)
      ST_VHI:  vaddr_o = base;
      ST_VLO:  vaddr_o = base + LO_OFS;
      default: vaddr_o = '0;
    endcase
  end
endmodule

// File: rtl/dbg_brk_inject.sv
module dbg_brk_inject
  import dbg_brk_pkg::*;
#(
  parameter int          OP_W     = 8,
  parameter int          ADDR_W   = 16,
  parameter logic [OP_W-1:0]   SWI_OP   = 8'h83,
  parameter logic [ADDR_W-1:0] VEC_NORM = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_MON  = 16'hFEFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_match_i,
  input  logic              instr_last_i,
  input  logic              monitor_i,
  input  logic              rti_done_i,
  input  logic              brk_req_i,
  output logic              op_force_o,
  output logic [OP_W-1:0]   op_code_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              in_service_o
);
  logic    hit, take;
  brk_st_e st;

  brk_pend_latch u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .match_i (addr_match_i),
    .idle_i  (st == ST_IDLE),
    .take_i  (take),
    .hit_o   (hit)
  );

  brk_seq_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit),
    .last_i (instr_last_i),
    .rti_i  (rti_done_i),
    .req_i  (brk_req_i),
    .take_o (take),
    .st_o   (st)
  );

  brk_vec_gen #(
    .OP_W(OP_W), .ADDR_W(ADDR_W), .SWI_OP(SWI_OP),
    .VEC_NORM(VEC_NORM), .VEC_MON(VEC_MON)
  ) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take),
    .mon_i    (monitor_i),
    .st_i     (st),
    .force_o  (op_force_o),
    .code_o   (op_code_o),
    .vvalid_o (vec_valid_o),
    .vaddr_o  (vec_addr_o)
  );

  assign in_service_o = (st != ST_IDLE);
endmodule

// File: rtl/dbg_brk_inject_chk.sv
module dbg_brk_inject_chk #(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 16,
  parameter logic [OP_W-1:0] SWI_OP = 8'h83
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_match_i,
  input logic              instr_last_i,
  input logic              rti_done_i,
  input logic              brk_req_i,
  input logic              op_force_o,
  input logic [OP_W-1:0]   op_code_o,
  input logic              vec_valid_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic              in_service_o
);
  logic in_svc_phase;
  assign in_svc_phase = in_service_o && !op_force_o && !vec_valid_o;

  p_no_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_last_i |=> !op_force_o);

  p_immediate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_service_o && instr_last_i && addr_match_i) |=> op_force_o);

  p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_force_o |=> !op_force_o);

  p_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_force_o |-> (op_code_o == SWI_OP));

  p_vec_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_force_o |=> (vec_valid_o && !vec_addr_o[0]));

  p_vec_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_addr_o[0]) |=> (vec_valid_o && vec_addr_o[0]));

  p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_phase && rti_done_i && !brk_req_i) |=> !in_service_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_phase && brk_req_i) |=> in_service_o);

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_service_o |=> !op_force_o);
endmodule

bind dbg_brk_inject dbg_brk_inject_chk #(
  .OP_W(OP_W), .ADDR_W(ADDR_W), .SWI_OP(SWI_OP)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_match_i (addr_match_i),
  .instr_last_i (instr_last_i),
  .rti_done_i   (rti_done_i),
  .brk_req_i    (brk_req_i),
  .op_force_o   (op_force_o),
  .op_code_o    (op_code_o),
  .vec_valid_o  (vec_valid_o),
  .vec_addr_o   (vec_addr_o),
  .in_service_o (in_service_o)
);

// File: tb/dbg_brk_inject_test.sv
module dbg_brk_inject_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic match = 1'b0, last = 1'b0, mon = 1'b0, rti = 1'b0, req = 1'b0;
  logic        force_o, vvalid, insvc;
  logic [7:0]  code;
  logic [15:0] vaddr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model: 0 idle, 1 override, 2 vec high, 3 vec low, 4 service
  int m_st = 0;
  bit m_pend = 1'b0, m_mon = 1'b0;

  always #5 clk = ~clk;

  dbg_brk_inject uut (
    .clk(clk), .rst_n(rst_n), .addr_match_i(match), .instr_last_i(last),
    .monitor_i(mon), .rti_done_i(rti), .brk_req_i(req),
    .op_force_o(force_o), .op_code_o(code), .vec_valid_o(vvalid),
    .vec_addr_o(vaddr), .in_service_o(insvc)
  );

  function automatic logic [15:0] exp_addr(int st, bit m);
    logic [15:0] b = m ? 16'hFEFC : 16'hFFFC;
    if (st == 2) return b;
    if (st == 3) return b + 16'd1;
    return 16'h0000;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "force R4", {15'd0, force_o}, {15'd0, m_st == 1});
    chk(tag, "code R4", {8'd0, code}, (m_st == 1) ? 16'h0083 : 16'h0000);
    chk(tag, "vvalid R5", {15'd0, vvalid}, {15'd0, (m_st == 2) || (m_st == 3)});
    chk(tag, "vaddr R5/R6", vaddr, exp_addr(m_st, m_mon));
    chk(tag, "in_service R7", {15'd0, insvc}, {15'd0, m_st != 0});
  endtask

  // one cycle: check outputs, apply inputs, advance the model over the edge
  task automatic step(string tag, bit a, bit l, bit m, bit r, bit q);
    @(negedge clk);
    compare(tag);
    match = a; last = l; mon = m; rti = r; req = q;
    case (m_st)
      0: if (l && (m_pend || a)) begin m_st = 1; m_pend = 0; m_mon = m; end
         else m_pend = m_pend | a;
      1: m_st = 2;
      2: m_st = 3;
      3: m_st = 4;
      default: if (r && !q) m_st = 0;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first cycle after reset, boundary without match
    step("R1", 0, 1, 0, 0, 0);
    // R10: many boundaries, no match
    for (int i = 0; i < 6; i++) step("R10", 0, 1, i[0], 1, 0);
    // R3 + R4 + R5: match on the final cycle
    step("R3", 1, 1, 0, 0, 1);
    for (int i = 0; i < 4; i++) step("R5", 0, 0, 1, 0, 1);
    // R8: return while request held
    step("R8", 0, 1, 0, 1, 1);
    step("R8", 0, 0, 0, 1, 1);
    // R9: match during service, then exit and boundaries without match
    step("R9", 1, 1, 0, 0, 1);
    step("R9", 1, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 1, 0);
    for (int i = 0; i < 5; i++) step("R9", 0, 1, 0, 0, 0);
    // R2: mid-instruction match, long instruction, then boundary
    step("R2", 1, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R2", 0, 0, 0, 0, 0);
    // R6: monitor mode sampled at the boundary
    step("R6", 0, 1, 1, 0, 0);
    for (int i = 0; i < 4; i++) step("R6", 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 0);
    step("R7", 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++)
      step("RND", ($urandom % 8) == 0, ($urandom % 3) == 0, $urandom % 2,
           ($urandom % 5) == 0, $urandom % 2);
    step("RND", 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule